// File: doc/BRIEF.md
# Bus-Sampled Fault Capture Register

This block collects error reports from the system bus and from two asynchronous fault lines into one 16-bit fault word. The word is numbered MSB-first: fault bit n is vector index 15-n. The block watches the active-low bus-busy line, which is synchronous to the CPU clock. At the end of every bus cycle it samples three active-low error inputs: memory protection, memory parity and external address. The rising transition of the busy line marks the end of a cycle. Each error lands in a fixed bit. For protection errors the bit depends on whether this processor owned the cycle. For address errors it depends on whether the cycle was a memory or an I/O access. Cycles run by other bus masters are captured too, because the busy line is shared.

Two asynchronous fault inputs pass through a synchronizer and a rising-edge detector. Each detected edge sets its own bit or bits. Captured bits stay set until reset or until software clears them with a masked clear. When a new fault and a clear target the same bit in the same cycle, the new fault wins. A summary flag shows whether any bit is set.

Top module: `fault_capture`

## Requirements
- R1: While `rstN` is low and after its release, `faultWord` is all zero and `faultAny` is low.
- R2: Bus error inputs are sampled only at a clock edge where `busBusyN` is high and was low at the previous edge. Errors present at any other edge have no effect on the word.
- R3: A low `protErrN` at a bus-cycle end sets fault bit 0 (index 15) when `ownCycle` is 1, and fault bit 1 (index 14) when `ownCycle` is 0.
- R4: A low `parErrN` at a bus-cycle end sets fault bit 2 (index 13), whatever the ownership or cycle type.
- R5: A low `addrErrN` at a bus-cycle end sets fault bit 5 (index 10) when `memCycle` is 1, and fault bit 8 (index 7) when `memCycle` is 0.
- R6: A 0-to-1 transition of `sysFault0` sets fault bit 7 (index 8). The bit is visible two clock edges after the edge that first samples the high level. A level that stays high does not set the bit again.
- R7: A 0-to-1 transition of `sysFault1` sets both fault bit 13 (index 2) and fault bit 15 (index 0), with the same latency as R6.
- R8: Set bits are sticky. At an edge with `clrValid` high, each word index whose `clrMask` bit is 1 is cleared, and the other indices keep their value.
- R9: If a set event and a masked clear hit the same index at the same edge, that index ends up set.
- R10: `faultAny` is high exactly when `faultWord` is non-zero. It changes in the same cycle as the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busBusyN | input | 1 | Shared bus-busy line, active low |
| ownCycle | input | 1 | 1 when the finishing bus cycle belongs to this CPU |
| memCycle | input | 1 | 1 for a memory cycle, 0 for an I/O cycle |
| protErrN | input | 1 | Memory protection error, active low |
| parErrN | input | 1 | Memory parity error, active low |
| addrErrN | input | 1 | External address error, active low |
| sysFault0 | input | 1 | Asynchronous fault line, rising-edge sensitive |
| sysFault1 | input | 1 | Asynchronous fault line, rising-edge sensitive |
| clrValid | input | 1 | Software clear strobe |
| clrMask | input | 16 | Per-index clear mask, same indexing as faultWord |
| faultWord | output | 16 | Captured fault bits, fault bit n at index 15-n |
| faultAny | output | 1 | High when any captured bit is set |

## Verification
A bus-cycle end that carries an error can fall on the same edge as a software clear whose mask covers the bit being set. The same holds for a synchronized fault edge. The bench builds both cases on purpose: it raises the busy line with an error asserted while `clrValid` is high, and it times a fault pulse so that its detected edge meets a clear. The reference model applies the clear first and then ORs in the new events, so the result is judged bit by bit against that model. Randomized traffic mixes the two functions further.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  localparam int WORD_W = 16;

  // MSB-first fault numbering: fault bit n lives at vector index WORD_W-1-n
  localparam int IDX_PROT_OWN   = WORD_W - 1 - 0;
  localparam int IDX_PROT_OTHER = WORD_W - 1 - 1;
  localparam int IDX_PARITY     = WORD_W - 1 - 2;
  localparam int IDX_ADDR_MEM   = WORD_W - 1 - 5;
  localparam int IDX_SYS0       = WORD_W - 1 - 7;
  localparam int IDX_ADDR_IO    = WORD_W - 1 - 8;
  localparam int IDX_SYS1_A     = WORD_W - 1 - 13;
  localparam int IDX_SYS1_B     = WORD_W - 1 - 15;

  localparam int NUM_ASYNC = 2;

  typedef struct packed {
    logic protOwn;
    logic protOther;
    logic parity;
    logic addrMem;
    logic addrIo;
    logic sys0;
    logic sys1;
    logic clear;
  } faultStrobes_t;
endpackage

// File: rtl/fault_sync_edge.sv
module fault_sync_edge #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] risePulse
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < CHAIN; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign risePulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/fault_ctrl.sv
module fault_ctrl
  import fault_capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busBusyN,
  input  logic          ownCycle,
  input  logic          memCycle,
  input  logic          protErrN,
  input  logic          parErrN,
  input  logic          addrErrN,
  input  logic          sysFault0,
  input  logic          sysFault1,
  input  logic          clrValid,
  output faultStrobes_t strobes
);
  logic                 busPrevN;
  logic                 busEnd;
  logic [NUM_ASYNC-1:0] sysRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busPrevN <= 1'b1;
    else       busPrevN <= busBusyN;
  end

  assign busEnd = busBusyN & ~busPrevN;

  fault_sync_edge #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .asyncIn  ({sysFault1, sysFault0}),
    .risePulse(sysRise)
  );

  always_comb begin
    strobes           = '0;
    strobes.protOwn   = busEnd & ~protErrN & ownCycle;
    strobes.protOther = busEnd & ~protErrN & ~ownCycle;
    strobes.parity    = busEnd & ~parErrN;
    strobes.addrMem   = busEnd & ~addrErrN & memCycle;
    strobes.addrIo    = busEnd & ~addrErrN & ~memCycle;
    strobes.sys0      = sysRise[0];
    strobes.sys1      = sysRise[1];
    strobes.clear     = clrValid;
  end
endmodule

// File: rtl/fault_datapath.sv
module fault_datapath
  import fault_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  faultStrobes_t     strobes,
  input  logic [WORD_W-1:0] clrMask,
  output logic [WORD_W-1:0] faultWord,
  output logic              faultAny
);
  logic [WORD_W-1:0] setVec;
  logic [WORD_W-1:0] keepVec;
  logic [WORD_W-1:0] nextWord;

  always_comb begin
    setVec                 = '0;
    setVec[IDX_PROT_OWN]   = strobes.protOwn;
    setVec[IDX_PROT_OTHER] = strobes.protOther;
    setVec[IDX_PARITY]     = strobes.parity;
    setVec[IDX_ADDR_MEM]   = strobes.addrMem;
    setVec[IDX_ADDR_IO]    = strobes.addrIo;
    setVec[IDX_SYS0]       = strobes.sys0;
    setVec[IDX_SYS1_A]     = strobes.sys1;
    setVec[IDX_SYS1_B]     = strobes.sys1;
  end

  assign keepVec  = strobes.clear ? ~clrMask : '1;
  assign nextWord = (faultWord & keepVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultWord <= '0;
      faultAny  <= 1'b0;
    end else begin
      faultWord <= nextWord;
      faultAny  <= |nextWord;
    end
  end
endmodule

// File: rtl/fault_capture.sv
module fault_capture
  import fault_capture_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busBusyN,
  input  logic              ownCycle,
  input  logic              memCycle,
  input  logic              protErrN,
  input  logic              parErrN,
  input  logic              addrErrN,
  input  logic              sysFault0,
  input  logic              sysFault1,
  input  logic              clrValid,
  input  logic [WORD_W-1:0] clrMask,
  output logic [WORD_W-1:0] faultWord,
  output logic              faultAny
);
  faultStrobes_t strobes;

  fault_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busBusyN (busBusyN),
    .ownCycle (ownCycle),
    .memCycle (memCycle),
    .protErrN (protErrN),
    .parErrN  (parErrN),
    .addrErrN (addrErrN),
    .sysFault0(sysFault0),
    .sysFault1(sysFault1),
    .clrValid (clrValid),
    .strobes  (strobes)
  );

  fault_datapath uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .clrMask  (clrMask),
    .faultWord(faultWord),
    .faultAny (faultAny)
  );
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk
  import fault_capture_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busBusyN,
  input logic              ownCycle,
  input logic              memCycle,
  input logic              protErrN,
  input logic              parErrN,
  input logic              addrErrN,
  input logic              clrValid,
  input logic [WORD_W-1:0] clrMask,
  input logic [WORD_W-1:0] faultWord,
  input logic              faultAny
);
  localparam logic [WORD_W-1:0] BUS_MASK =
    (WORD_W'(1) << IDX_PROT_OWN) | (WORD_W'(1) << IDX_PROT_OTHER) |
    (WORD_W'(1) << IDX_PARITY)   | (WORD_W'(1) << IDX_ADDR_MEM)   |
    (WORD_W'(1) << IDX_ADDR_IO);

  // R3
  prot_own_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busBusyN) && !protErrN && ownCycle) |=> faultWord[IDX_PROT_OWN]);

  // R3
  prot_other_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busBusyN) && !protErrN && !ownCycle) |=> faultWord[IDX_PROT_OTHER]);

  // R4
  parity_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busBusyN) && !parErrN) |=> faultWord[IDX_PARITY]);

  // R5
  addr_type_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busBusyN) && !addrErrN) |=>
      (memCycle ? faultWord[IDX_ADDR_MEM] : faultWord[IDX_ADDR_IO]) || !$past(memCycle) == memCycle);

  // R2
  quiet_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busBusyN |=> ((faultWord & BUS_MASK & ~$past(faultWord)) == '0));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clrValid |=> ((~faultWord & $past(faultWord)) == '0));

  // R10
  summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultAny == (faultWord != '0));
endmodule

bind fault_capture fault_capture_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .busBusyN (busBusyN),
  .ownCycle (ownCycle),
  .memCycle (memCycle),
  .protErrN (protErrN),
  .parErrN  (parErrN),
  .addrErrN (addrErrN),
  .clrValid (clrValid),
  .clrMask  (clrMask),
  .faultWord(faultWord),
  .faultAny (faultAny)
);

// File: tb/fault_capture_test.sv
module fault_capture_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busBusyN = 1'b1;
  logic        ownCycle = 1'b1;
  logic        memCycle = 1'b1;
  logic        protErrN = 1'b1;
  logic        parErrN = 1'b1;
  logic        addrErrN = 1'b1;
  logic        sysFault0 = 1'b0;
  logic        sysFault1 = 1'b0;
  logic        clrValid = 1'b0;
  logic [15:0] clrMask = '0;
  logic [15:0] faultWord;
  logic        faultAny;

  int    vectors = 0;
  int    miscompares = 0;
  bit    checking = 0;
  bit    done = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_capture uut (
    .clk(clk), .rstN(rstN), .busBusyN(busBusyN), .ownCycle(ownCycle),
    .memCycle(memCycle), .protErrN(protErrN), .parErrN(parErrN),
    .addrErrN(addrErrN), .sysFault0(sysFault0), .sysFault1(sysFault1),
    .clrValid(clrValid), .clrMask(clrMask), .faultWord(faultWord),
    .faultAny(faultAny)
  );

  // ---------------- reference model ----------------
  logic [15:0] model = '0;
  logic        prevBusy = 1'b1;
  logic        hist0[$];
  logic        hist1[$];

  function automatic logic histAt(input logic q[$], input int i);
    return (i < q.size()) ? q[i] : 1'b0;
  endfunction

  function automatic string reqOfBit(input int idx);
    case (idx)
      15, 14: return "R3";
      13:     return "R4";
      10, 7:  return "R5";
      8:      return "R6";
      2, 0:   return "R7";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    logic [15:0] setV;
    if (!rstN) begin
      model = '0;
      prevBusy = 1'b1;
      hist0.delete();
      hist1.delete();
    end else begin
      hist0.push_front(sysFault0);
      hist1.push_front(sysFault1);
      if (hist0.size() > 8) void'(hist0.pop_back());
      if (hist1.size() > 8) void'(hist1.pop_back());
      setV = '0;
      if (busBusyN && !prevBusy) begin
        if (!protErrN) setV[ownCycle ? 15 : 14] = 1'b1;
        if (!parErrN)  setV[13] = 1'b1;
        if (!addrErrN) setV[memCycle ? 10 : 7] = 1'b1;
      end
      if (histAt(hist0, 2) && !histAt(hist0, 3)) setV[8] = 1'b1;
      if (histAt(hist1, 2) && !histAt(hist1, 3)) begin
        setV[2] = 1'b1;
        setV[0] = 1'b1;
      end
      model = (model & ~(clrValid ? clrMask : 16'h0)) | setV;
      prevBusy = busBusyN;
    end
  end

  // compare on every falling edge, before stimulus changes
  always @(negedge clk) begin
    if (checking) begin
      vectors++;
      for (int b = 0; b < 16; b++) begin
        if (faultWord[b] !== model[b]) begin
          miscompares++;
          $display("FAIL %s index %0d [%s]: got %b expected %b (word %h vs %h)",
                   reqOfBit(b), b, phase, faultWord[b], model[b], faultWord, model);
        end
      end
      if (faultAny !== (model != 0)) begin
        miscompares++;
        $display("FAIL R10 [%s]: faultAny got %b expected %b", phase, faultAny, (model != 0));
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busCycle(input bit own, input bit mem, input bit prot,
                          input bit par, input bit addr, input int lowLen,
                          input bit clr, input logic [15:0] mask);
    @(negedge clk);
    busBusyN = 1'b0; ownCycle = own; memCycle = mem;
    idle(lowLen);
    busBusyN = 1'b1;
    protErrN = ~prot; parErrN = ~par; addrErrN = ~addr;
    clrValid = clr; clrMask = mask;
    @(negedge clk);
    protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
    clrValid = 1'b0; clrMask = '0;
  endtask

  task automatic clearBits(input logic [15:0] mask);
    @(negedge clk);
    clrValid = 1'b1; clrMask = mask;
    @(negedge clk);
    clrValid = 1'b0; clrMask = '0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state observed while reset is held
    vectors++;
    if (faultWord !== 16'h0 || faultAny !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: got %h/%b expected 0000/0", faultWord, faultAny);
    end
    rstN = 1'b1;
    checking = 1;
    idle(2);

    phase = "R3 own-cycle protect";
    busCycle(1, 1, 1, 0, 0, 2, 0, '0); idle(2);
    phase = "R3 foreign-cycle protect";
    busCycle(0, 1, 1, 0, 0, 1, 0, '0); idle(2);
    phase = "R8 masked clear";
    clearBits(16'h8000); idle(2);
    phase = "R4 parity foreign io";
    busCycle(0, 0, 0, 1, 0, 3, 0, '0); idle(2);
    phase = "R5 address memory";
    busCycle(1, 1, 0, 0, 1, 1, 0, '0); idle(2);
    phase = "R5 address io";
    busCycle(1, 0, 0, 0, 1, 1, 0, '0); idle(2);
    phase = "R8 clear all";
    clearBits(16'hFFFF); idle(2);

    // R2: errors while busy stays low, removed before the rising edge
    phase = "R2 errors mid-cycle";
    @(negedge clk);
    busBusyN = 1'b0;
    idle(1);
    protErrN = 1'b0; parErrN = 1'b0; addrErrN = 1'b0;
    idle(2);
    protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
    idle(1);
    busBusyN = 1'b1;
    idle(2);
    // R2: errors while the bus is idle
    phase = "R2 errors on idle bus";
    protErrN = 1'b0; parErrN = 1'b0; addrErrN = 1'b0;
    idle(4);
    protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
    idle(2);

    phase = "R6 system fault 0 pulse";
    sysFault0 = 1'b1; idle(1); sysFault0 = 1'b0; idle(5);
    phase = "R7 system fault 1 pulse";
    sysFault1 = 1'b1; idle(2); sysFault1 = 1'b0; idle(5);
    phase = "R6 held level after clear";
    sysFault0 = 1'b1; idle(5);
    clearBits(16'hFFFF); idle(6);
    sysFault0 = 1'b0; idle(3);

    phase = "R9 bus set versus clear";
    busCycle(1, 1, 1, 1, 0, 1, 1, 16'hFFFF); idle(2);
    phase = "R9 fault edge versus clear";
    clearBits(16'hFFFF);
    sysFault1 = 1'b1;
    idle(2);
    clrValid = 1'b1; clrMask = 16'hFFFF;
    idle(1);
    clrValid = 1'b0; clrMask = '0;
    sysFault1 = 1'b0;
    idle(4);

    phase = "R2 mixed random traffic";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busBusyN  = lfsr[0] | lfsr[5];
      ownCycle  = lfsr[1];
      memCycle  = lfsr[2];
      protErrN  = lfsr[3] | lfsr[8];
      parErrN   = lfsr[4] | lfsr[9];
      addrErrN  = lfsr[6] | lfsr[11];
      sysFault0 = lfsr[7] & lfsr[12];
      sysFault1 = lfsr[13] & lfsr[14];
      clrValid  = lfsr[15] & lfsr[10];
      clrMask   = {lfsr[7:0], lfsr[15:8]};
      @(negedge clk);
    end
    busBusyN = 1'b1; protErrN = 1'b1; parErrN = 1'b1; addrErrN = 1'b1;
    sysFault0 = 1'b0; sysFault1 = 1'b0; clrValid = 1'b0; clrMask = '0;
    idle(6);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule